// File: doc/BRIEF.md
# Serial Register-Access Port

This block is the slave side of a four-wire serial link (active-low select, master-driven serial clock, data in, data out). It gives an external controller byte-wide access to a 256-location register space. All register traffic goes through an internal 8-bit address pointer. The block contains the register store itself. Locations 0x00 to 0xCF are read/write storage. Locations 0xD0 to 0xEF are protected and read back a fixed parameter value. Locations 0xF0 to 0xFF are unpopulated.

Every select-low period is one frame, and its first byte always sets the pointer. Further bytes in that frame are stored at the pointer, which steps up by one after each byte. A frame that carries only the address byte arms a read. The frame that follows then streams register contents out, MSB first, from the stored pointer, which keeps stepping up byte after byte. The serial pins are oversampled in the system clock domain. The data output comes with a separate output-enable, so the pad ring can float the line while the port is deselected.

Top module: `spi_regport`

## Requirements
- R1: While `cs_n` is high, `miso_oe` is 0 and serial clock or data activity changes no register and no pointer state. `miso_oe` is 1 while `cs_n` is low.
- R2: In a frame not armed as a read, the first byte loads the pointer, and each later complete byte is stored at the pointer, after which the pointer steps up by one.
- R3: `mosi` is sampled on rising `sclk` edges. `miso` changes only after falling `sclk` edges or the start of a frame, so it is stable while `sclk` is high. Bytes go MSB first on both lines.
- R4: A frame that ends after exactly one complete byte arms a read. In the next frame, each byte clocked shifts out the register at the pointer, and the pointer then steps up by one. Data on `mosi` during that frame is ignored.
- R5: The pointer wraps from 0xFF to 0x00, for writes and for read streams.
- R6: Writes to 0xD0 through 0xEF are dropped, and those locations always read back `RSV_VAL` (default 0x3C).
- R7: Locations 0xF0 through 0xFF discard writes and read back 0x00.
- R8: When `cs_n` rises partway through a byte, the incomplete bits are dropped and cause no write. The pointer only changes on a complete byte.
- R9: The armed read is cleared at the end of the next frame, whatever that frame contains. Any frame that does not directly follow an address-only frame is a write frame, including one that follows an empty frame.
- R10: After reset, every storage location reads 0x00, the pointer is 0x00, no read is armed, and `miso_oe` follows `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the master |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, valid when `miso_oe` is 1 |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
The hardest state to reach is the armed-read flag in combination with frame boundaries. It is only visible through what the next frame does, and an empty frame or a cut-off byte silently changes that. The stimulus arms a read and then inserts an empty select pulse. It then sends what looks like a read frame and proves by readback that the frame was taken as a write. A separate sequence arms a read, streams one byte with `mosi` held at all ones, and then checks that neighbouring registers were not written. Write streams that run across 0xCF into the protected region, and read streams that run across 0xFF, cover the address boundaries.

// File: rtl/spi_regport_pkg.sv
`timescale 1ns/1ps
package spi_regport_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t RW_LAST   = 8'hCF;
  localparam addr_t RSV_FIRST = 8'hD0;
  localparam addr_t RSV_LAST  = 8'hEF;
  localparam int    NUM_RW    = int'(RW_LAST) + 1;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_idle,
  output logic mosi_s
);
  logic [STAGES:0] sck_q, sck_d;
  logic [STAGES:0] cs_q, cs_d;
  logic [STAGES:0] mo_q, mo_d;

  always_comb begin
    sck_d = {sck_q[STAGES-1:0], sclk_i};
    cs_d  = {cs_q[STAGES-1:0], cs_n_i};
    mo_d  = {mo_q[STAGES-1:0], mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      mo_q  <= '0;
    end else begin
      sck_q <= sck_d;
      cs_q  <= cs_d;
      mo_q  <= mo_d;
    end
  end

  assign cs_idle  = cs_q[STAGES-1];
  assign mosi_s   = mo_q[STAGES-1];
  assign cs_fall  = ~cs_q[STAGES-1] &  cs_q[STAGES];
  assign cs_rise  =  cs_q[STAGES-1] & ~cs_q[STAGES];
  assign sck_rise =  sck_q[STAGES-1] & ~sck_q[STAGES] & ~cs_q[STAGES-1];
  assign sck_fall = ~sck_q[STAGES-1] &  sck_q[STAGES] & ~cs_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
  import spi_regport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  cs_fall,
  input  logic  cs_rise,
  input  logic  mosi_s,
  input  data_t rd_data,
  output addr_t ptr,
  output logic  wr_en,
  output addr_t wr_addr,
  output data_t wr_data,
  output logic  miso_bit
);
  localparam logic [1:0] NB_SAT = 2'd2;

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [1:0]       nb_q, nb_d;
  data_t            shin_q, shin_d, shout_q, shout_d, wdat_q, wdat_d;
  addr_t            ptr_q, ptr_d, wadr_q, wadr_d;
  logic             pend_q, pend_d, rdm_q, rdm_d, we_q, we_d;
  data_t            byte_in;

  assign byte_in = {shin_q[DATA_W-2:0], mosi_s};

  always_comb begin
    bit_d   = bit_q;
    nb_d    = nb_q;
    shin_d  = shin_q;
    shout_d = shout_q;
    ptr_d   = ptr_q;
    pend_d  = pend_q;
    rdm_d   = rdm_q;
    we_d    = 1'b0;
    wadr_d  = wadr_q;
    wdat_d  = wdat_q;
    if (cs_fall) begin
      bit_d   = '0;
      nb_d    = '0;
      rdm_d   = pend_q;
      shout_d = rd_data;
    end else if (cs_rise) begin
      pend_d = ~rdm_q & (nb_q == 2'd1);
      rdm_d  = 1'b0;
      bit_d  = '0;
    end else if (sck_rise) begin
      shin_d = byte_in;
      bit_d  = bit_q + 1'b1;
      if (bit_q == BIT_W'(DATA_W - 1)) begin
        if (rdm_q) begin
          ptr_d = ptr_q + 1'b1;
        end else if (nb_q == 2'd0) begin
          ptr_d = byte_in;
        end else begin
          we_d   = 1'b1;
          wadr_d = ptr_q;
          wdat_d = byte_in;
          ptr_d  = ptr_q + 1'b1;
        end
        if (nb_q != NB_SAT) nb_d = nb_q + 1'b1;
      end
    end else if (sck_fall) begin
      if (bit_q == '0) shout_d = rd_data;
      else             shout_d = {shout_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      nb_q    <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      ptr_q   <= '0;
      pend_q  <= 1'b0;
      rdm_q   <= 1'b0;
      we_q    <= 1'b0;
      wadr_q  <= '0;
      wdat_q  <= '0;
    end else begin
      bit_q   <= bit_d;
      nb_q    <= nb_d;
      shin_q  <= shin_d;
      shout_q <= shout_d;
      ptr_q   <= ptr_d;
      pend_q  <= pend_d;
      rdm_q   <= rdm_d;
      we_q    <= we_d;
      wadr_q  <= wadr_d;
      wdat_q  <= wdat_d;
    end
  end

  assign ptr      = ptr_q;
  assign wr_en    = we_q;
  assign wr_addr  = wadr_q;
  assign wr_data  = wdat_q;
  assign miso_bit = shout_q[DATA_W-1];
endmodule

// File: rtl/spi_regfile.sv
`timescale 1ns/1ps
module spi_regfile
  import spi_regport_pkg::*;
#(
  parameter data_t RSV_VAL = 8'h3C
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  data_t wr_data,
  input  addr_t rd_addr,
  output data_t rd_data
);
  data_t mem_q [NUM_RW];
  logic  store_en;

  assign store_en = wr_en & (wr_addr <= RW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RW; i++) mem_q[i] <= '0;
    end else if (store_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr <= RW_LAST)       rd_data = mem_q[rd_addr];
    else if (rd_addr <= RSV_LAST) rd_data = RSV_VAL;
    else                          rd_data = '0;
  end
endmodule

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter data_t RSV_VAL     = 8'h3C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic       sck_rise, sck_fall, cs_fall, cs_rise, cs_idle, mosi_s;
  logic       wr_en, miso_bit;
  addr_t      ptr, wr_addr;
  data_t      wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_idle(cs_idle), .mosi_s(mosi_s)
  );

  spi_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sn), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s), .rd_data(rd_data),
    .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso_bit(miso_bit)
  );

  spi_regfile #(.RSV_VAL(RSV_VAL)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
  );

  assign miso    = miso_bit;
  assign miso_oe = ~cs_n;
endmodule

// File: rtl/spi_regport_chk.sv
`timescale 1ns/1ps
module spi_regport_chk
  import spi_regport_pkg::*;
#(
  parameter data_t RSV_VAL = 8'h3C
) (
  input logic  clk,
  input logic  rst_sn,
  input logic  miso,
  input logic  cs_idle,
  input logic  sck_rise,
  input logic  sck_fall,
  input logic  cs_fall,
  input logic  wr_en,
  input addr_t wr_addr,
  input addr_t ptr,
  input data_t rd_data
);
  assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_idle |=> !wr_en);

  assert_write_steps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en |-> (ptr == addr_t'(wr_addr + 1'b1)));

  assert_miso_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (miso != $past(miso)) |-> ($past(sck_fall) || $past(cs_fall)));

  assert_ptr_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (ptr != $past(ptr)) |-> $past(sck_rise));

  assert_protected_value_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (ptr >= RSV_FIRST && ptr <= RSV_LAST) |-> (rd_data == RSV_VAL));

  assert_empty_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (ptr > RSV_LAST) |-> (rd_data == '0));
endmodule

bind spi_regport spi_regport_chk #(.RSV_VAL(RSV_VAL)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .miso(miso), .cs_idle(cs_idle),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
  .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr), .rd_data(rd_data)
);

// File: tb/spi_regport_tb.sv
`timescale 1ns/1ps
module spi_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 83;
  localparam logic [7:0] RSV = 8'h3C;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mosi;
  logic miso, miso_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx_byte;
  event       rx_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(rx_ev) begin
    if (exp_q.size() == 0) begin
      chk(1'b0, "R4", "unexpected read byte", int'(rx_byte), 0);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rx_byte == e, t, "read byte", int'(rx_byte), int'(e));
    end
  end

  task automatic xfer(input logic [7:0] tx, input int nbits, input bit hold_chk,
                      output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      #SCK_HALF;
      rx[i] = miso;
      sclk = 1'b1;
      #SCK_HALF;
      if (hold_chk) chk(miso == rx[i], "R3", "miso stable while sclk high",
                        int'(miso), int'(rx[i]));
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    #(3*SCK_HALF);
    chk(miso_oe == 1'b1, "R1", "oe while selected", int'(miso_oe), 1);
  endtask

  task automatic cs_hi();
    #SCK_HALF;
    cs_n = 1'b1;
    #(3*SCK_HALF);
    chk(miso_oe == 1'b0, "R1", "oe while deselected", int'(miso_oe), 0);
  endtask

  task automatic wr_frame(input logic [7:0] addr, input logic [7:0] base,
                          input int n, input logic [7:0] step);
    logic [7:0] a, d, rx;
    a = addr;
    cs_lo();
    xfer(addr, 8, 1'b0, rx);
    for (int i = 0; i < n; i++) begin
      d = base + 8'(i) * step;
      xfer(d, 8, 1'b0, rx);
      if (a <= 8'hCF) model[a] = d;
      a = a + 1'b1;
    end
    cs_hi();
  endtask

  task automatic rd_frame(input logic [7:0] addr, input int n, input string tag);
    logic [7:0] a, rx;
    a = addr;
    cs_lo();
    xfer(addr, 8, 1'b0, rx);
    cs_hi();
    cs_lo();
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[a]);
      tag_q.push_back(tag);
      xfer(8'hFF, 8, 1'b1, rx);
      rx_byte = rx;
      ->rx_ev;
      a = a + 1'b1;
    end
    cs_hi();
  endtask

  initial begin
    #(150000*CLK_PERIOD);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 256; i++)
      model[i] = (i >= 8'hD0 && i <= 8'hEF) ? RSV : 8'h00;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    #(5*CLK_PERIOD + 3);
    chk(miso_oe == 1'b0, "R10", "oe in reset", int'(miso_oe), 0);
    rst_n = 1'b1;
    #(6*CLK_PERIOD);

    // R10: storage clear, no armed read after reset
    rd_frame(8'h00, 3, "R10");

    // R2 R3 R4: write burst then read it back
    wr_frame(8'h10, 8'hA1, 4, 8'h11);
    rd_frame(8'h10, 4, "R2");
    wr_frame(8'h60, 8'h80, 3, 8'h01);
    rd_frame(8'h5F, 5, "R4");

    // R6: write stream across the protected boundary
    wr_frame(8'hCE, 8'h71, 4, 8'h01);
    rd_frame(8'hCD, 6, "R6");

    // R7: unpopulated locations discard writes and read zero
    wr_frame(8'hF0, 8'hEE, 2, 8'h01);
    rd_frame(8'hEE, 4, "R7");

    // R5: pointer wraps on read and on write
    wr_frame(8'h00, 8'h5A, 2, 8'h01);
    rd_frame(8'hFE, 4, "R5");
    wr_frame(8'hFF, 8'h21, 2, 8'h01);
    rd_frame(8'hFF, 3, "R5");

    // R8: byte cut short by deselect is dropped
    cs_lo();
    xfer(8'h10, 8, 1'b0, rx);
    xfer(8'h99, 8, 1'b0, rx);
    xfer(8'hFF, 5, 1'b0, rx);
    cs_hi();
    model[8'h10] = 8'h99;
    rd_frame(8'h10, 2, "R8");

    // R1: activity while deselected is ignored
    for (int i = 0; i < 16; i++) begin
      mosi = i[0];
      #SCK_HALF; sclk = 1'b1;
      chk(miso_oe == 1'b0, "R1", "oe idle clocking", int'(miso_oe), 0);
      #SCK_HALF; sclk = 1'b0;
    end
    rd_frame(8'h10, 2, "R1");

    // R9 R4: read frame ignores mosi, the following frame writes
    rd_frame(8'h40, 1, "R4");
    wr_frame(8'h40, 8'h66, 1, 8'h00);
    rd_frame(8'h40, 2, "R9");

    // R9: empty frame clears an armed read
    cs_lo(); xfer(8'h50, 8, 1'b0, rx); cs_hi();
    cs_lo(); cs_hi();
    wr_frame(8'h50, 8'h77, 1, 8'h00);
    rd_frame(8'h50, 2, "R9");

    #(4*CLK_PERIOD);
    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule